// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Signed-Overflow Trap

This block is the combinational integer datapath of a load-store processor's execute stage. From a 4-bit operation code, two register operands, a 5-bit shift-amount field, a 16-bit immediate and an immediate-select flag, it forms a 32-bit result and a single overflow-exception flag in the same cycle. Exception handling, and any multiply or divide, are left to the surrounding pipeline. The pipeline samples the result and the flag together on its own clock edge.

The block has a wrapping form and a trapping form of add and subtract. It also has the four bitwise operations, signed and unsigned set-less-than, three shift kinds and a load-upper-immediate. When the immediate-select flag is high, the immediate stands in for the second operand. Bitwise operations zero-extend it and arithmetic and compare operations sign-extend it. For shifts, the same flag chooses whether the amount comes from the instruction field or from the second register. There is no stream of data to pace, so the block has no valid/ready handshake.

Top module: `int_alu`

## Requirements
- R1: With op 0 (add) and op 2 (subtract), result is the wrapped 32-bit sum or difference a±b, and ovf is 1 exactly when that operation overflows as a signed two's-complement value.
- R2: Op 1 (add, no trap) and op 3 (subtract, no trap) give the same result as op 0 and op 2 and always hold ovf at 0.
- R3: Every op other than 0 and 2 holds ovf at 0. This covers the bitwise operations, the compares, the shifts and LUI.
- R4: With imm_sel=1, ops 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR) use the immediate zero-extended to 32 bits in place of b.
- R5: With imm_sel=1, ops 0, 1, 2, 3, 8 and 9 use the immediate sign-extended from bit 15 in place of b.
- R6: Op 8 gives 1 when a<b as signed values, else 0. Op 9 gives 1 when a<b as unsigned values, else 0. Bits 31..1 of the result are 0 for both.
- R7: Op 10 shifts a left and op 11 shifts a right, both filling with zeros. Op 12 shifts a right, filling with copies of a[31]. An amount of 0 returns a unchanged.
- R8: For shifts, imm_sel=1 takes the amount from shamt and ignores b. With imm_sel=0 the amount is b[4:0], and b[31:5] is ignored.
- R9: Op 13 (LUI) gives the immediate in bits 31..16 and zeros in bits 15..0, whatever a and b hold.
- R10: Op 7 gives the bitwise inverse of (a OR b).
- R11: Op codes 14 and 15 are unused. They give result 0 and ovf 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0 add, 1 add no-trap, 2 sub, 3 sub no-trap, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 signed less-than, 9 unsigned less-than, 10 shift left, 11 logical right, 12 arithmetic right, 13 LUI) |
| a_i | input | 32 | First operand; the value shifted by shift ops |
| b_i | input | 32 | Second operand; low 5 bits give the variable shift amount |
| shamt_i | input | 5 | Constant shift amount from the instruction field |
| imm_i | input | 16 | Instruction immediate |
| imm_sel_i | input | 1 | 1: immediate replaces b, or shamt is used for shifts |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed-overflow exception request |

## Verification
The bench goes after the signed-overflow edges: the most positive value plus one, the most negative value minus one, and the sum of two negatives that does not overflow. A design that tested the carry-out instead of the sign rule would trap on the last case, and one that let the no-trap opcodes raise the flag would trap on the first. The bench feeds a value with bit 15 set through AND, OR, XOR and through add and unsigned compare. This catches an extension swapped between the bitwise and arithmetic groups. It compares all-ones against one under both less-than forms, shifts by 0 and by 31, and gives a variable amount whose upper bits are set. A shifter that reads those bits would clear the result. It also runs LUI with nonzero a and b, so an operand leaking into the result would show.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12,
    OP_LUI  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/int_alu_operand.sv
module int_alu_operand #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  b_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               imm_sel_i,
  output logic [DATA_W-1:0]  b_arith_o,
  output logic [DATA_W-1:0]  b_logic_o,
  output logic [SHAMT_W-1:0] amt_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext;
  logic [DATA_W-1:0] imm_zext;

  assign imm_sext  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign imm_zext  = {{EXT_W{1'b0}}, imm_i};
  assign b_arith_o = imm_sel_i ? imm_sext : b_i;
  assign b_logic_o = imm_sel_i ? imm_zext : b_i;
  assign amt_o     = imm_sel_i ? shamt_i : b_i[SHAMT_W-1:0];

  always_comb begin
    // R4: zero extension leaves the upper part clear
    if (imm_sel_i) begin
      a_r4_zext_upper: assert (b_logic_o[DATA_W-1:IMM_W] == '0);
    end
    // R5: sign extension replicates immediate bit 15
    if (imm_sel_i) begin
      a_r5_sext_upper: assert (b_arith_o[DATA_W-1] == imm_i[IMM_W-1]);
    end
  end
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              lt_s_o,
  output logic              lt_u_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign wide   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o  = wide[MSB:0];
  // same-sign operands giving a different-sign result
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  assign lt_s_o = sum_o[MSB] ^ ovf_o;
  assign lt_u_o = ~wide[DATA_W];

  always_comb begin
    // R1: add overflow needs operands of equal sign
    if (ovf_o && !sub_i) begin
      a_r1_add_ovf_signs: assert (a_i[MSB] == b_i[MSB]);
    end
    // R1: subtract overflow needs operands of opposite sign
    if (ovf_o && sub_i) begin
      a_r1_sub_ovf_signs: assert (a_i[MSB] != b_i[MSB]);
    end
    // R6: equal operands are never less-than
    if (sub_i && (a_i == b_i)) begin
      a_r6_equal_not_less: assert (!lt_s_o && !lt_u_o);
    end
  end
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        fn_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      2'd2:    y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

  always_comb begin
    // R10: NOR result never shares a set bit with either operand
    if (fn_i == 2'd3) begin
      a_r10_nor_disjoint: assert ((y_o & (a_i | b_i)) == '0);
    end
  end
endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter
  import int_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  shift_kind_e        kind_i,
  output logic [DATA_W-1:0]  y_o
);
  localparam int MSB = DATA_W - 1;

  logic                            go_left;
  logic                            fill;
  logic [SHAMT_W:0][DATA_W-1:0]    stg;

  assign go_left = (kind_i == SH_LEFT);
  assign fill    = (kind_i == SH_RARI) & a_i[MSB];
  assign stg[0]  = a_i;

  for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
    localparam int S = 1 << i;
    logic [DATA_W-1:0] shl;
    logic [DATA_W-1:0] shr;
    assign shl        = {stg[i][MSB-S:0], {S{1'b0}}};
    assign shr        = {{S{fill}}, stg[i][MSB:S]};
    assign stg[i+1]   = !amt_i[i] ? stg[i] : (go_left ? shl : shr);
  end

  assign y_o = stg[SHAMT_W];

  always_comb begin
    // R7: arithmetic right shift of a negative value stays negative
    if (kind_i == SH_RARI) begin
      a_r7_sra_sign_fill: assert (y_o[MSB] == a_i[MSB]);
    end
    // R7: logical right shift by a nonzero amount clears the top bit
    if ((kind_i == SH_RLOG) && (amt_i != '0)) begin
      a_r7_srl_zero_fill: assert (!y_o[MSB]);
    end
    // R7: left shift by a nonzero amount clears bit 0
    if ((kind_i == SH_LEFT) && (amt_i != '0)) begin
      a_r7_sll_zero_fill: assert (!y_o[0]);
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [3:0]         op_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic               imm_sel_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               ovf_o
);
  localparam int LOW_W = DATA_W - IMM_W;

  alu_op_e           op;
  logic [DATA_W-1:0] b_arith;
  logic [DATA_W-1:0] b_logic;
  logic [SHAMT_W-1:0] amt;
  logic              do_sub;
  logic [DATA_W-1:0] sum;
  logic              raw_ovf;
  logic              lt_s;
  logic              lt_u;
  logic [DATA_W-1:0] logic_y;
  logic [DATA_W-1:0] shift_y;
  shift_kind_e       sh_kind;
  logic              trap_op;

  assign op = alu_op_e'(op_i);

  int_alu_operand #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .SHAMT_W(SHAMT_W)
  ) u_operand (
    .b_i      (b_i),
    .imm_i    (imm_i),
    .shamt_i  (shamt_i),
    .imm_sel_i(imm_sel_i),
    .b_arith_o(b_arith),
    .b_logic_o(b_logic),
    .amt_o    (amt)
  );

  assign do_sub = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);

  int_alu_addsub #(
    .DATA_W(DATA_W)
  ) u_addsub (
    .a_i   (a_i),
    .b_i   (b_arith),
    .sub_i (do_sub),
    .sum_o (sum),
    .ovf_o (raw_ovf),
    .lt_s_o(lt_s),
    .lt_u_o(lt_u)
  );

  int_alu_logic #(
    .DATA_W(DATA_W)
  ) u_logic (
    .a_i (a_i),
    .b_i (b_logic),
    .fn_i(op_i[1:0]),
    .y_o (logic_y)
  );

  always_comb begin
    unique case (op)
      OP_SRL:  sh_kind = SH_RLOG;
      OP_SRA:  sh_kind = SH_RARI;
      default: sh_kind = SH_LEFT;
    endcase
  end

  int_alu_shifter #(
    .DATA_W (DATA_W),
    .SHAMT_W(SHAMT_W)
  ) u_shifter (
    .a_i   (a_i),
    .amt_i (amt),
    .kind_i(sh_kind),
    .y_o   (shift_y)
  );

  assign trap_op = (op == OP_ADD) || (op == OP_SUB);
  assign ovf_o   = trap_op & raw_ovf;

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    result_o = logic_y;
      OP_SLT:                           result_o = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:                          result_o = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA:           result_o = shift_y;
      OP_LUI:                           result_o = {imm_i, {LOW_W{1'b0}}};
      default:                          result_o = '0;
    endcase
  end

  always_comb begin
    // R6: compare results are a single bit wide
    if ((op == OP_SLT) || (op == OP_SLTU)) begin
      a_r6_compare_bool: assert (result_o[DATA_W-1:1] == '0);
    end
    // R9: LUI lower half is zero
    if (op == OP_LUI) begin
      a_r9_lui_low_zero: assert (result_o[LOW_W-1:0] == '0);
    end
    // R3: only the trapping add and subtract may flag overflow
    if (ovf_o) begin
      a_r3_no_overflow: assert ((op_i == 4'd0) || (op_i == 4'd2));
    end
    // R11: unused codes yield zero
    if (op_i >= 4'd14) begin
      a_r11_unused_zero: assert ((result_o == '0) && !ovf_o);
    end
  end
endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;
  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  sh;
    logic [15:0] imm;
    logic        sel;
    logic [31:0] exp_r;
    logic        exp_v;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  32'h7fffffff, 32'h00000001, 5'd0,  16'h0000, 1'b0, 32'h80000000, 1'b1, 4'd1},  // R1
    '{4'd0,  32'h00000005, 32'h00000003, 5'd0,  16'h0000, 1'b0, 32'h00000008, 1'b0, 4'd1},  // R1
    '{4'd2,  32'h80000000, 32'h00000001, 5'd0,  16'h0000, 1'b0, 32'h7fffffff, 1'b1, 4'd1},  // R1
    '{4'd0,  32'hffffffff, 32'hffffffff, 5'd0,  16'h0000, 1'b0, 32'hfffffffe, 1'b0, 4'd1},  // R1
    '{4'd2,  32'h7fffffff, 32'hffffffff, 5'd0,  16'h0000, 1'b0, 32'h80000000, 1'b1, 4'd1},  // R1
    '{4'd1,  32'h7fffffff, 32'h00000001, 5'd0,  16'h0000, 1'b0, 32'h80000000, 1'b0, 4'd2},  // R2
    '{4'd3,  32'h00000000, 32'h00000001, 5'd0,  16'h0000, 1'b0, 32'hffffffff, 1'b0, 4'd2},  // R2
    '{4'd3,  32'h80000000, 32'h00000001, 5'd0,  16'h0000, 1'b0, 32'h7fffffff, 1'b0, 4'd2},  // R2
    '{4'd4,  32'hff00ff00, 32'h0ff00ff0, 5'd0,  16'h0000, 1'b0, 32'h0f000f00, 1'b0, 4'd3},  // R3
    '{4'd4,  32'hffffffff, 32'h00000000, 5'd0,  16'h8000, 1'b1, 32'h00008000, 1'b0, 4'd4},  // R4
    '{4'd5,  32'h00000000, 32'hffffffff, 5'd0,  16'hffff, 1'b1, 32'h0000ffff, 1'b0, 4'd4},  // R4
    '{4'd6,  32'hffff0000, 32'h00000000, 5'd0,  16'hffff, 1'b1, 32'hffffffff, 1'b0, 4'd4},  // R4
    '{4'd7,  32'h00000000, 32'hffffffff, 5'd0,  16'h8000, 1'b1, 32'hffff7fff, 1'b0, 4'd4},  // R4
    '{4'd1,  32'h00000010, 32'h00000000, 5'd0,  16'hfffe, 1'b1, 32'h0000000e, 1'b0, 4'd5},  // R5
    '{4'd0,  32'h7fffffff, 32'h00000000, 5'd0,  16'h0001, 1'b1, 32'h80000000, 1'b1, 4'd5},  // R5
    '{4'd9,  32'h00000005, 32'h00000000, 5'd0,  16'hffff, 1'b1, 32'h00000001, 1'b0, 4'd5},  // R5
    '{4'd8,  32'hffffffff, 32'h00000001, 5'd0,  16'h0000, 1'b0, 32'h00000001, 1'b0, 4'd6},  // R6
    '{4'd9,  32'hffffffff, 32'h00000001, 5'd0,  16'h0000, 1'b0, 32'h00000000, 1'b0, 4'd6},  // R6
    '{4'd8,  32'h00000002, 32'h00000001, 5'd0,  16'h0000, 1'b0, 32'h00000000, 1'b0, 4'd6},  // R6
    '{4'd8,  32'h80000000, 32'h7fffffff, 5'd0,  16'h0000, 1'b0, 32'h00000001, 1'b0, 4'd6},  // R6
    '{4'd10, 32'h00000001, 32'h00000000, 5'd31, 16'h0000, 1'b1, 32'h80000000, 1'b0, 4'd7},  // R7
    '{4'd11, 32'h80000000, 32'h00000000, 5'd4,  16'h0000, 1'b1, 32'h08000000, 1'b0, 4'd7},  // R7
    '{4'd12, 32'h80000000, 32'h00000000, 5'd4,  16'h0000, 1'b1, 32'hf8000000, 1'b0, 4'd7},  // R7
    '{4'd12, 32'h80000001, 32'h00000000, 5'd0,  16'h0000, 1'b1, 32'h80000001, 1'b0, 4'd7},  // R7
    '{4'd12, 32'hf0000000, 32'hffffffe4, 5'd0,  16'h0000, 1'b0, 32'hff000000, 1'b0, 4'd8},  // R8
    '{4'd11, 32'h12345678, 32'h00000020, 5'd9,  16'h0000, 1'b0, 32'h12345678, 1'b0, 4'd8},  // R8
    '{4'd10, 32'h00000003, 32'h00000005, 5'd1,  16'h0000, 1'b1, 32'h00000006, 1'b0, 4'd8},  // R8
    '{4'd7,  32'h0f0f0f0f, 32'h00ff00ff, 5'd0,  16'h0000, 1'b0, 32'hf000f000, 1'b0, 4'd10}  // R10
  };

  logic        clk;
  logic [3:0]  op;
  logic [31:0] a;
  logic [31:0] b;
  logic [4:0]  sh;
  logic [15:0] imm;
  logic        sel;
  logic [31:0] res;
  logic        ovf;
  int          n_chk;
  int          n_err;
  bit          done;

  int_alu dut_i (
    .op_i     (op),
    .a_i      (a),
    .b_i      (b),
    .shamt_i  (sh),
    .imm_i    (imm),
    .imm_sel_i(sel),
    .result_o (res),
    .ovf_o    (ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic drive(input logic [3:0] o, input logic [31:0] xa, input logic [31:0] xb,
                       input logic [4:0] s, input logic [15:0] i, input logic e);
    @(negedge clk);
    op = o; a = xa; b = xb; sh = s; imm = i; sel = e;
    #5;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic ev);
    n_chk++;
    if ((res !== er) || (ovf !== ev)) begin
      n_err++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b", tag, res, ovf, er, ev);
    end
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    op = '0; a = '0; b = '0; sh = '0; imm = '0; sel = 1'b0;
    repeat (2) @(posedge clk);

    // idle state: zero inputs on add give zero and no trap (R1)
    drive(4'd0, 32'h0, 32'h0, 5'd0, 16'h0, 1'b0);
    check("R1 idle", 32'h0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].op, VECS[k].a, VECS[k].b, VECS[k].sh, VECS[k].imm, VECS[k].sel);
      check($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].exp_r, VECS[k].exp_v);
    end

    // R9: LUI ignores a and b
    drive(4'd13, 32'hffffffff, 32'hffffffff, 5'd7, 16'habcd, 1'b1);
    check("R9 lui busy operands", 32'habcd0000, 1'b0);
    drive(4'd13, 32'h0, 32'h0, 5'd0, 16'h8001, 1'b0);
    check("R9 lui quiet operands", 32'h80010000, 1'b0);

    // R11: unused codes
    drive(4'd14, 32'h7fffffff, 32'h00000001, 5'd3, 16'hffff, 1'b0);
    check("R11 code 14", 32'h0, 1'b0);
    drive(4'd15, 32'hffffffff, 32'hffffffff, 5'd3, 16'hffff, 1'b1);
    check("R11 code 15", 32'h0, 1'b0);

    // R3: shifts and compares on overflow-prone values do not trap
    drive(4'd10, 32'h7fffffff, 32'h00000001, 5'd1, 16'h0, 1'b1);
    check("R3 shift no trap", 32'hfffffffe, 1'b0);
    drive(4'd8, 32'h7fffffff, 32'h80000000, 5'd0, 16'h0, 1'b0);
    check("R3 compare no trap", 32'h0, 1'b0);

    // R2: no-trap add matches trapping add result over a sweep
    for (int k = 0; k < 8; k++) begin
      logic [31:0] xa;
      logic [31:0] xb;
      xa = 32'h7ffffff0 + 32'(k * 5);
      xb = 32'h00000007 * 32'(k + 1);
      drive(4'd1, xa, xb, 5'd0, 16'h0, 1'b0);
      check("R2 sweep", xa + xb, 1'b0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: result=%h ovf=%b expected result=completion ovf=-", res, ovf);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule